// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file for a processor that gives each procedure its own set of registers. The physical storage is divided into a ring of windows. Each window has three banks of eight: incoming parameters, private locals and outgoing temporaries. A shared bank of eight global registers sits beside the ring. A call steps the current window pointer forward by one and a return steps it back. The outgoing temporaries of a window use the same physical storage as the incoming parameters of the next window. Arguments and results therefore cross the call boundary with no copy.

Two combinational read ports and one clocked write port take a 5-bit logical register number. Each port translates that number through the current window pointer. A saved window pointer marks the oldest window still held in the file. A call that would reach that window raises a one-cycle overflow trap and waits until a spill-done input confirms that the oldest window was written to memory. A return from the oldest resident window raises a one-cycle underflow trap and waits for a fill-done input. The trap handler and the memory transfer engine are outside this block.

Top module: `regwin_file`

## Requirements
- R1: Logical numbers 0-7 select the globals, 8-15 the parameters, 16-23 the locals and 24-31 the temporaries. A global holds the same value in every window.
- R2: Temporary t of window w is the same storage as parameter t of window (w+1) mod 8. A value written to temporary t before a call reads back as parameter t after the call, and the reverse holds across a return.
- R3: Locals are private to their window. A local written in a window keeps its value across nested calls and the matching returns.
- R4: An accepted call sets cwp_o to (cwp_o+1) mod 8 on the next edge. An accepted return sets it to (cwp_o-1) mod 8.
- R5: A call issued when (cwp_o+1) mod 8 equals swp_o leaves cwp_o unchanged and drives ovf_trap_o high for exactly one cycle, the cycle after the call edge. From reset, the call issued at nesting depth 8 is the first to trap.
- R6: spill_done_i while an overflow is pending increments swp_o and cwp_o on the same edge and ends the pending state.
- R7: A return issued when cwp_o equals swp_o leaves cwp_o unchanged and drives unf_trap_o high for exactly one cycle.
- R8: fill_done_i while an underflow is pending decrements swp_o and cwp_o on the same edge and ends the pending state.
- R9: While a trap is pending, call_i and ret_i are ignored. A done input that does not match the pending trap kind is also ignored.
- R10: When the write port and a read port select the same register in one cycle, the read port returns the write data in that cycle.
- R11: After reset, cwp_o and swp_o are 0, both traps are low and every register reads 0.
- R12: call_i and ret_i asserted in the same cycle have no effect.
- R13: A write issued in the same cycle as a call or a return uses the window that was current before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call request |
| ret_i | input | 1 | Procedure return request |
| spill_done_i | input | 1 | Oldest window has been saved to memory |
| fill_done_i | input | 1 | Window has been restored from memory |
| rd_a_addr_i | input | 5 | Logical register, read port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_addr_i | input | 5 | Logical register, read port B |
| rd_b_data_o | output | 32 | Read data, port B |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register, write port |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer (oldest resident window) |
| ovf_trap_o | output | 1 | Window overflow trap, one-cycle pulse |
| unf_trap_o | output | 1 | Window underflow trap, one-cycle pulse |

## Verification
Two things can happen in the same cycle: a register write and a window switch. The write must land in the window that is current before the edge, not in the one that becomes current. The bench drives we_i together with call_i to write a temporary, then reads the matching parameter in the callee. It drives we_i together with ret_i to write a local, then calls back into that window and reads the local. A write and a read of the same register can also meet in one cycle. This case is judged by the read data seen before the edge.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  // logical register bank, taken from the two top bits of a register number
  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_PAR = 2'd1,
    GRP_LOC = 2'd2,
    GRP_TMP = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/regwin_map.sv
module regwin_map
  import regwin_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int WIN_W = 3,
  parameter int LA_W  = 5,
  parameter int PH_W  = 8
) (
  input  logic [WIN_W-1:0] cwp_i,
  input  logic [LA_W-1:0]  laddr_i,
  output logic [PH_W-1:0]  paddr_o
);
  localparam int IDX_W  = LA_W - 2;
  localparam int SLOT_W = WIN_W + 1 + IDX_W;

  reg_grp_e           grp;
  logic [IDX_W-1:0]   idx;
  logic [WIN_W-1:0]   win;
  logic [SLOT_W-1:0]  slot;

  always_comb begin
    grp = reg_grp_e'(laddr_i[LA_W-1 -: 2]);
    idx = laddr_i[IDX_W-1:0];
    // temporaries alias the parameters of the next window in the ring
    win = (grp == GRP_TMP) ? cwp_i + WIN_W'(1) : cwp_i;
    slot = {win, (grp == GRP_LOC), idx};
    if (grp == GRP_GLB) paddr_o = PH_W'(idx);
    else                paddr_o = PH_W'(NREG) + PH_W'(slot);
  end
endmodule

// File: rtl/regwin_storage.sv
module regwin_storage #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PH_W  = 8,
  parameter int NRD   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [PH_W-1:0]          waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NRD-1:0][PH_W-1:0] raddr_i,
  output logic [NRD-1:0][DW-1:0]   rdata_o
);
  logic [DW-1:0] mem_q [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    // write-first forwarding
    assign rdata_o[p] = (we_i && waddr_i == raddr_i[p]) ? wdata_i : mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/regwin_wptr.sv
module regwin_wptr #(
  parameter int WIN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             spill_done_i,
  input  logic             fill_done_i,
  output logic [WIN_W-1:0] cwp_o,
  output logic [WIN_W-1:0] swp_o,
  output logic             ovf_trap_o,
  output logic             unf_trap_o,
  output logic             ovf_pend_o,
  output logic             unf_pend_o
);
  logic [WIN_W-1:0] cwp_q, swp_q, cwp_inc, cwp_dec;
  logic             ovf_pend_q, unf_pend_q, ovf_trap_q, unf_trap_q;
  logic             busy, call_ok, ret_ok;

  always_comb begin
    busy    = ovf_pend_q | unf_pend_q;
    call_ok = call_i & ~ret_i & ~busy;
    ret_ok  = ret_i & ~call_i & ~busy;
    cwp_inc = cwp_q + WIN_W'(1);
    cwp_dec = cwp_q - WIN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q      <= '0;
      swp_q      <= '0;
      ovf_pend_q <= 1'b0;
      unf_pend_q <= 1'b0;
      ovf_trap_q <= 1'b0;
      unf_trap_q <= 1'b0;
    end else begin
      ovf_trap_q <= 1'b0;
      unf_trap_q <= 1'b0;
      if (call_ok) begin
        if (cwp_inc == swp_q) begin
          ovf_pend_q <= 1'b1;
          ovf_trap_q <= 1'b1;
        end else begin
          cwp_q <= cwp_inc;
        end
      end
      if (ret_ok) begin
        if (cwp_q == swp_q) begin
          unf_pend_q <= 1'b1;
          unf_trap_q <= 1'b1;
        end else begin
          cwp_q <= cwp_dec;
        end
      end
      // held call completes once the oldest window is out
      if (ovf_pend_q && spill_done_i) begin
        swp_q      <= swp_q + WIN_W'(1);
        cwp_q      <= cwp_inc;
        ovf_pend_q <= 1'b0;
      end
      if (unf_pend_q && fill_done_i) begin
        swp_q      <= swp_q - WIN_W'(1);
        cwp_q      <= cwp_dec;
        unf_pend_q <= 1'b0;
      end
    end
  end

  assign cwp_o      = cwp_q;
  assign swp_o      = swp_q;
  assign ovf_trap_o = ovf_trap_q;
  assign unf_trap_o = unf_trap_q;
  assign ovf_pend_o = ovf_pend_q;
  assign unf_pend_o = unf_pend_q;
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  parameter int DW   = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                call_i,
  input  logic                                ret_i,
  input  logic                                spill_done_i,
  input  logic                                fill_done_i,
  input  logic [$clog2(NREG)+1:0]             rd_a_addr_i,
  output logic [DW-1:0]                       rd_a_data_o,
  input  logic [$clog2(NREG)+1:0]             rd_b_addr_i,
  output logic [DW-1:0]                       rd_b_data_o,
  input  logic                                we_i,
  input  logic [$clog2(NREG)+1:0]             wr_addr_i,
  input  logic [DW-1:0]                       wr_data_i,
  output logic [$clog2(NWIN)-1:0]             cwp_o,
  output logic [$clog2(NWIN)-1:0]             swp_o,
  output logic                                ovf_trap_o,
  output logic                                unf_trap_o
);
  localparam int WIN_W = $clog2(NWIN);
  localparam int IDX_W = $clog2(NREG);
  localparam int LA_W  = IDX_W + 2;
  localparam int NPHYS = NREG + NWIN * 2 * NREG;
  localparam int PH_W  = $clog2(NPHYS);
  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;

  logic                       ovf_pend, unf_pend;
  logic [NPORT-1:0][LA_W-1:0] laddr;
  logic [NPORT-1:0][PH_W-1:0] paddr;
  logic [NRD-1:0][PH_W-1:0]   raddr;
  logic [NRD-1:0][DW-1:0]     rdata;

  regwin_wptr #(.WIN_W(WIN_W)) u_wptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .spill_done_i (spill_done_i),
    .fill_done_i  (fill_done_i),
    .cwp_o        (cwp_o),
    .swp_o        (swp_o),
    .ovf_trap_o   (ovf_trap_o),
    .unf_trap_o   (unf_trap_o),
    .ovf_pend_o   (ovf_pend),
    .unf_pend_o   (unf_pend)
  );

  // port order: 0 = read A, 1 = read B, 2 = write
  assign laddr = {wr_addr_i, rd_b_addr_i, rd_a_addr_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    regwin_map #(.NREG(NREG), .WIN_W(WIN_W), .LA_W(LA_W), .PH_W(PH_W)) u_map (
      .cwp_i   (cwp_o),
      .laddr_i (laddr[p]),
      .paddr_o (paddr[p])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_ra
    assign raddr[p] = paddr[p];
  end

  regwin_storage #(.DW(DW), .NPHYS(NPHYS), .PH_W(PH_W), .NRD(NRD)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .waddr_i (paddr[NRD]),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int WIN_W = 3,
  parameter int LA_W  = 5,
  parameter int DW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             call_i,
  input logic             ret_i,
  input logic             spill_done_i,
  input logic             fill_done_i,
  input logic             we_i,
  input logic [LA_W-1:0]  wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [LA_W-1:0]  rd_a_addr_i,
  input logic [DW-1:0]    rd_a_data_o,
  input logic [WIN_W-1:0] cwp_o,
  input logic [WIN_W-1:0] swp_o,
  input logic             ovf_trap_o,
  input logic             unf_trap_o,
  input logic             ovf_pend,
  input logic             unf_pend
);
  // R4
  call_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !ovf_pend && !unf_pend && WIN_W'(cwp_o + WIN_W'(1)) != swp_o)
    |=> cwp_o == WIN_W'($past(cwp_o) + WIN_W'(1)));

  // R5
  ovf_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !ovf_pend && !unf_pend && WIN_W'(cwp_o + WIN_W'(1)) == swp_o)
    |=> ovf_trap_o && $stable(cwp_o));

  // R5
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_trap_o |=> !ovf_trap_o);

  // R6
  spill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_pend && spill_done_i)
    |=> swp_o == WIN_W'($past(swp_o) + WIN_W'(1)) && cwp_o == WIN_W'($past(cwp_o) + WIN_W'(1)));

  // R7
  unf_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !ovf_pend && !unf_pend && cwp_o == swp_o)
    |=> unf_trap_o && $stable(cwp_o));

  // R7
  unf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_trap_o |=> !unf_trap_o);

  // R8
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_pend && fill_done_i)
    |=> swp_o == WIN_W'($past(swp_o) - WIN_W'(1)) && cwp_o == WIN_W'($past(cwp_o) - WIN_W'(1)));

  // R9
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_pend && !spill_done_i) || (unf_pend && !fill_done_i))
    |=> $stable(cwp_o) && $stable(swp_o));

  // R10
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_addr_i == rd_a_addr_i) |-> rd_a_data_o == wr_data_i);

  // R12
  both_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i && !ovf_pend && !unf_pend) |=> $stable(cwp_o) && !ovf_trap_o && !unf_trap_o);
endmodule

bind regwin_file regwin_file_chk #(.WIN_W(WIN_W), .LA_W(LA_W), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .spill_done_i (spill_done_i),
  .fill_done_i  (fill_done_i),
  .we_i         (we_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .rd_a_addr_i  (rd_a_addr_i),
  .rd_a_data_o  (rd_a_data_o),
  .cwp_o        (cwp_o),
  .swp_o        (swp_o),
  .ovf_trap_o   (ovf_trap_o),
  .unf_trap_o   (unf_trap_o),
  .ovf_pend     (ovf_pend),
  .unf_pend     (unf_pend)
);

// File: tb/regwin_file_tb.sv
module regwin_file_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk, rst_n;
  logic        call, ret, spill_done, fill_done, we;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic [2:0]  cwp, swp;
  logic        ovf_trap, unf_trap;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  regwin_file u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .call_i       (call),
    .ret_i        (ret),
    .spill_done_i (spill_done),
    .fill_done_i  (fill_done),
    .rd_a_addr_i  (rd_a_addr),
    .rd_a_data_o  (rd_a_data),
    .rd_b_addr_i  (rd_b_addr),
    .rd_b_data_o  (rd_b_data),
    .we_i         (we),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .cwp_o        (cwp),
    .swp_o        (swp),
    .ovf_trap_o   (ovf_trap),
    .unf_trap_o   (unf_trap)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; wr_addr = a; wr_data = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    rd_a_addr = a;
    #0.5;
    chk(rd_a_data === exp, req, rd_a_data, exp);
  endtask

  task automatic do_call();
    call = 1'b1; tick(); call = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  task automatic t_reset();
    chk(cwp === 3'd0, "R11 cwp", 32'(cwp), 0);
    chk(swp === 3'd0, "R11 swp", 32'(swp), 0);
    chk(!ovf_trap && !unf_trap, "R11 traps", {30'd0, ovf_trap, unf_trap}, 0);
    for (int a = 0; a < 32; a += 5) rd_chk(5'(a), 32'd0, "R11 reg");
  endtask

  task automatic t_globals();
    wr_reg(5'd3, 32'h6100_0003);
    do_call();
    rd_b_addr = 5'd3;
    #0.5;
    chk(rd_b_data === 32'h6100_0003, "R1 global in window 1", rd_b_data, 32'h6100_0003);
    wr_reg(5'd3, 32'h6100_0013);
    do_ret();
    rd_chk(5'd3, 32'h6100_0013, "R1 global back in window 0");
  endtask

  task automatic t_pass();
    wr_reg(5'd29, 32'hA500_0005);          // temp 5, window 0
    do_call();
    chk(cwp === 3'd1, "R4 call step", 32'(cwp), 1);
    rd_chk(5'd13, 32'hA500_0005, "R2 temp to param");
    wr_reg(5'd8, 32'hB600_0000);           // param 0, window 1
    do_ret();
    chk(cwp === 3'd0, "R4 ret step", 32'(cwp), 0);
    rd_chk(5'd24, 32'hB600_0000, "R2 param to temp");
  endtask

  task automatic t_locals();
    for (int w = 0; w < 7; w++) begin
      wr_reg(5'd18, 32'hC000_0000 + 32'(w));
      do_call();
      chk(cwp === 3'(w + 1), "R4 nested call", 32'(cwp), 32'(w + 1));
    end
    for (int w = 6; w >= 0; w--) begin
      do_ret();
      chk(cwp === 3'(w), "R4 nested ret", 32'(cwp), 32'(w));
      rd_chk(5'd18, 32'hC000_0000 + 32'(w), "R3 local kept");
    end
  endtask

  task automatic t_overflow();
    for (int d = 0; d < 7; d++) begin
      do_call();
      chk(!ovf_trap, "R5 no trap before depth 8", 32'(ovf_trap), 0);
    end
    do_call();
    chk(ovf_trap === 1'b1, "R5 trap at depth 8", 32'(ovf_trap), 1);
    chk(cwp === 3'd7, "R5 cwp held", 32'(cwp), 7);
    do_call();                              // ignored while pending
    chk(ovf_trap === 1'b0, "R5 one-cycle pulse", 32'(ovf_trap), 0);
    chk(cwp === 3'd7, "R9 call ignored", 32'(cwp), 7);
    fill_done = 1'b1; tick(); fill_done = 1'b0;
    chk(swp === 3'd0, "R9 fill ignored", 32'(swp), 0);
    spill_done = 1'b1; tick(); spill_done = 1'b0;
    chk(swp === 3'd1, "R6 swp step", 32'(swp), 1);
    chk(cwp === 3'd0, "R6 call completes", 32'(cwp), 0);
  endtask

  task automatic t_underflow();
    for (int r = 0; r < 7; r++) do_ret();
    chk(cwp === 3'd1, "R4 unwind", 32'(cwp), 1);
    chk(!unf_trap, "R7 no early trap", 32'(unf_trap), 0);
    do_ret();
    chk(unf_trap === 1'b1, "R7 trap", 32'(unf_trap), 1);
    chk(cwp === 3'd1, "R7 cwp held", 32'(cwp), 1);
    ret = 1'b1; spill_done = 1'b1; tick(); ret = 1'b0; spill_done = 1'b0;
    chk(unf_trap === 1'b0, "R7 one-cycle pulse", 32'(unf_trap), 0);
    chk(cwp === 3'd1 && swp === 3'd1, "R9 ret and spill ignored", {cwp, swp}, {3'd1, 3'd1});
    fill_done = 1'b1; tick(); fill_done = 1'b0;
    chk(swp === 3'd0, "R8 swp back", 32'(swp), 0);
    chk(cwp === 3'd0, "R8 ret completes", 32'(cwp), 0);
  endtask

  task automatic t_bypass();
    we = 1'b1; wr_addr = 5'd17; wr_data = 32'hD00D_0017; rd_a_addr = 5'd17;
    #0.5;
    chk(rd_a_data === 32'hD00D_0017, "R10 forward", rd_a_data, 32'hD00D_0017);
    tick();
    we = 1'b0;
    rd_chk(5'd17, 32'hD00D_0017, "R10 stored");
  endtask

  task automatic t_same_cycle();
    we = 1'b1; wr_addr = 5'd30; wr_data = 32'hE000_0006; call = 1'b1;
    tick();
    we = 1'b0; call = 1'b0;
    chk(cwp === 3'd1, "R13 call taken", 32'(cwp), 1);
    rd_chk(5'd14, 32'hE000_0006, "R13 write-with-call window");
    call = 1'b1; ret = 1'b1; tick(); call = 1'b0; ret = 1'b0;
    chk(cwp === 3'd1 && !ovf_trap && !unf_trap, "R12 both ignored", 32'(cwp), 1);
    we = 1'b1; wr_addr = 5'd21; wr_data = 32'hF000_0015; ret = 1'b1;
    tick();
    we = 1'b0; ret = 1'b0;
    rd_chk(5'd21, 32'd0, "R13 window 0 local untouched");
    do_call();
    rd_chk(5'd21, 32'hF000_0015, "R13 write-with-ret window");
    do_ret();
  endtask

  initial begin
    rst_n = 1'b0; call = 0; ret = 0; spill_done = 0; fill_done = 0; we = 0;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_globals();
    t_pass();
    t_locals();
    t_overflow();
    t_underflow();
    t_bypass();
    t_same_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule